// File: doc/BRIEF.md
# Indirect Interrupt Redirection Controller

This block turns a small set of level-sensitive interrupt lines into 32-bit message writes aimed at a processor. Software reaches a table of 64-bit entries indirectly: it first writes an index into a select register, then reads or writes a data window that maps onto the table entry that index names. Each input line owns two neighbouring entries. The even one holds a six-bit vector together with mask, trigger and polarity bits. The odd one holds a destination in a bit-swizzled encoding.

A pending bitmap tracks which vectors are in service. When a line rises while it is unmasked and has a usable destination, the pending bit picked by the low bits of its vector is set. If that bit was clear before, a message is queued. Queued messages leave through a valid/ready output, lowest line number first. Software retires an interrupt by writing its vector to an end-of-interrupt offset. That write clears the pending bits of every line whose stored vector matches.

Accesses outside the decoded offsets follow a hard-fail option. With the option on, the access returns zero and flags an error. With it off, the access returns all ones and no error is flagged.

Top module: `irq_redirect`

## Requirements
- R1: After reset the pending bitmap is zero and no message is offered. For line i, the control entry at index 16+2i reads 0x1A000 | (i+2): mask bit 16, level bit 15, active-low bit 13, vector i+2. The destination entry at index 17+2i reads 0xA0FF0000, which is the encoded form of the default CPU address 0xFFFA0000.
- R2: A write to byte offset 0x800 loads the 8-bit select register, and a read of 0x800 returns it. Reads and writes at 0x810 reach the table entry named by the select value.
- R3: While the select value is 1, a read of 0x810 returns the version word (table size << 16) | 1, which is 0x00200001 for the default size, in place of entry 1.
- R4: Offsets other than 0x800, 0x810 and (for writes only) 0x840 are unmapped. Window accesses with a select value of 32 or more are also unmapped. An unmapped access changes no state. With hf_en=1 it returns rdata 0 and acc_err=1. With hf_en=0 it returns all ones and acc_err=0.
- R5: In a cycle where line i differs from its value in the previous cycle, the line is evaluated. If the line is high, mask bit 16 of its control entry is 0 and bits [31:0] of its destination entry are nonzero, pending bit vector[2:0] is set.
- R6: When an evaluated line is low, masked, or has a zero destination, pending bit vector[2:0] is cleared.
- R7: A message is queued only when R5 sets a pending bit that was clear before. Its data is the vector in bits [5:0], with bits [31:6] zero.
- R8: The message address is formed from the destination entry e as {4'hF, e[23:16], e[31:24], 12'h000}.
- R9: A message offered with msg_ready low stays offered with unchanged address and data. When several lines are queued, the lowest line number is offered first.
- R10: A write to offset 0x840 clears pending bit i for every line i whose stored vector[5:0] equals wdata[5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hf_en | input | 1 | Hard-fail option for unmapped accesses |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 13 | Byte offset of the access |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, valid in the access cycle |
| acc_err | output | 1 | Decode error in the access cycle |
| irq_lines | input | 8 | Level interrupt inputs, synchronous to clk |
| msg_ready | input | 1 | Consumer accepts the offered message |
| msg_valid | output | 1 | Message offered |
| msg_addr | output | 32 | Decoded destination address |
| msg_data | output | 32 | Message data carrying the vector |
| pend | output | 8 | Pending bitmap |

## Verification
The hardest case to reach is a backlog: several lines become pending in the same cycle while the consumer stalls. Two lines that share the low vector bits also have to meet, so that the second one raises no message. The stimulus first rewrites the control and destination entries through the window. It then raises three lines in one cycle with msg_ready held low, and later raises a fourth line whose vector aliases an occupied pending bit. A behavioural model checks on every clock that the bitmap, the stalled offer and the lowest-first drain order all match.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
   localparam int CTRL_BASE   = 16;
   localparam int VEC_W       = 6;
   localparam int MASK_BIT    = 16;
   localparam int LEVEL_BIT   = 15;
   localparam int POL_LOW_BIT = 13;
   localparam int VER_SEL     = 1;
   localparam int LINE_VEC_OFS = 2;
   localparam logic [12:0] OFS_SEL = 13'h800;
   localparam logic [12:0] OFS_WIN = 13'h810;
   localparam logic [12:0] OFS_EOI = 13'h840;

   function automatic logic [31:0] enc_dest(input logic [31:0] a);
      return {a[19:12], a[27:20], 16'h0000};
   endfunction

   function automatic logic [31:0] dec_dest(input logic [31:0] e);
      return {4'hF, e[23:16], e[31:24], 12'h000};
   endfunction

   function automatic logic [63:0] reset_entry(input int k, input int n_lines,
                                                input logic [31:0] def_cpu);
      logic [63:0] v;
      v = '0;
      if (k >= CTRL_BASE && k < CTRL_BASE + 2 * n_lines) begin
         if (((k - CTRL_BASE) % 2) == 0) begin
            v[MASK_BIT]    = 1'b1;
            v[LEVEL_BIT]   = 1'b1;
            v[POL_LOW_BIT] = 1'b1;
            v[VEC_W-1:0]   = VEC_W'((k - CTRL_BASE) / 2 + LINE_VEC_OFS);
         end else begin
            v[31:0] = enc_dest(def_cpu);
         end
      end
      return v;
   endfunction
endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
   import irq_redir_pkg::*;
#(
   parameter int DEPTH   = 32,
   parameter int N_LINES = 8,
   parameter int SEL_W   = 8,
   parameter int ADDR_W  = 13,
   parameter logic [31:0] DEF_CPU = 32'hFFFA_0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hf_en,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [63:0]       acc_wdata,
   output logic [63:0]       acc_rdata,
   output logic              acc_err,
   output logic [63:0]       ctrl_o [N_LINES],
   output logic [63:0]       dest_o [N_LINES],
   output logic              eoi_vld,
   output logic [VEC_W-1:0]  eoi_vec
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [63:0] VERSION = 64'((DEPTH << 16) | 1);

   logic [63:0]      tbl_q [DEPTH];
   logic [SEL_W-1:0] sel_q;
   logic [ADDR_W-1:0] aligned;
   logic hit_sel, hit_win, hit_eoi, sel_ok, rd_miss, wr_miss;
   logic [63:0] rd_val;

   assign aligned = {acc_addr[ADDR_W-1:3], 3'b000};
   assign hit_sel = aligned == ADDR_W'(OFS_SEL);
   assign hit_win = aligned == ADDR_W'(OFS_WIN);
   assign hit_eoi = aligned == ADDR_W'(OFS_EOI);
   assign sel_ok  = 32'(sel_q) < DEPTH;

   always_comb begin
      rd_val  = '0;
      rd_miss = 1'b0;
      if (hit_sel)
         rd_val = 64'(sel_q);
      else if (hit_win && 32'(sel_q) == VER_SEL)
         rd_val = VERSION;
      else if (hit_win && sel_ok)
         rd_val = tbl_q[sel_q[IDX_W-1:0]];
      else
         rd_miss = 1'b1;
   end

   assign wr_miss   = !(hit_sel || hit_eoi || (hit_win && sel_ok));
   assign acc_err   = acc_en && hf_en && (acc_wr ? wr_miss : rd_miss);
   assign acc_rdata = (acc_en && !acc_wr) ?
                      (rd_miss ? (hf_en ? 64'd0 : '1) : rd_val) : 64'd0;
   assign eoi_vld   = acc_en && acc_wr && hit_eoi;
   assign eoi_vec   = acc_wdata[VEC_W-1:0];

   always_ff @(posedge clk) begin
      if (rst)
         sel_q <= '0;
      else if (acc_en && acc_wr && hit_sel)
         sel_q <= acc_wdata[SEL_W-1:0];
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      always_ff @(posedge clk) begin
         if (rst)
            tbl_q[k] <= reset_entry(k, N_LINES, DEF_CPU);
         else if (acc_en && acc_wr && hit_win && sel_ok &&
                  sel_q[IDX_W-1:0] == IDX_W'(k))
            tbl_q[k] <= acc_wdata;
      end
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      assign ctrl_o[i] = tbl_q[CTRL_BASE + 2 * i];
      assign dest_o[i] = tbl_q[CTRL_BASE + 2 * i + 1];
   end
endmodule

// File: rtl/irq_redir_pend.sv
module irq_redir_pend
   import irq_redir_pkg::*;
#(
   parameter int N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINES-1:0] lines,
   input  logic [63:0]        ctrl_i [N_LINES],
   input  logic [63:0]        dest_i [N_LINES],
   input  logic               eoi_vld,
   input  logic [VEC_W-1:0]   eoi_vec,
   input  logic [N_LINES-1:0] take,
   output logic [N_LINES-1:0] pend,
   output logic [N_LINES-1:0] req
);
   localparam int PB_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

   logic [N_LINES-1:0] prev_q, pend_q, req_q, pend_d, new_req;
   logic [PB_W-1:0]    bidx;

   always_comb begin
      pend_d  = pend_q;
      new_req = '0;
      bidx    = '0;
      if (eoi_vld) begin
         for (int i = 0; i < N_LINES; i++)
            if (ctrl_i[i][VEC_W-1:0] == eoi_vec) pend_d[i] = 1'b0;
      end
      for (int i = 0; i < N_LINES; i++) begin
         if (lines[i] != prev_q[i]) begin
            bidx = ctrl_i[i][PB_W-1:0];
            if (lines[i] && !ctrl_i[i][MASK_BIT] && dest_i[i][31:0] != 32'd0) begin
               if (!pend_d[bidx]) new_req[i] = 1'b1;
               pend_d[bidx] = 1'b1;
            end else begin
               pend_d[bidx] = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= '0;
         pend_q <= '0;
         req_q  <= '0;
      end else begin
         prev_q <= lines;
         pend_q <= pend_d;
         req_q  <= (req_q & ~take) | new_req;
      end
   end

   assign pend = pend_q;
   assign req  = req_q;
endmodule

// File: rtl/irq_redir_msg.sv
module irq_redir_msg
   import irq_redir_pkg::*;
#(
   parameter int N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_LINES-1:0] req,
   input  logic [63:0]        ctrl_i [N_LINES],
   input  logic [63:0]        dest_i [N_LINES],
   input  logic               ready,
   output logic [N_LINES-1:0] take,
   output logic               valid,
   output logic [31:0]        addr,
   output logic [31:0]        data
);
   localparam int LN_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

   logic [LN_W-1:0] pick;
   logic            load, vld_q;
   logic [31:0]     addr_q, data_q;

   always_comb begin
      pick = '0;
      for (int i = N_LINES - 1; i >= 0; i--)
         if (req[i]) pick = LN_W'(i);
   end

   assign load = (|req) && (!vld_q || ready);

   always_comb begin
      take = '0;
      if (load) take[pick] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         vld_q  <= 1'b1;
         addr_q <= dec_dest(dest_i[pick][31:0]);
         data_q <= 32'(ctrl_i[pick][VEC_W-1:0]);
      end else if (ready) begin
         vld_q  <= 1'b0;
      end
   end

   assign valid = vld_q;
   assign addr  = addr_q;
   assign data  = data_q;
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
   import irq_redir_pkg::*;
#(
   parameter int DEPTH   = 32,
   parameter int N_LINES = 8,
   parameter int SEL_W   = 8,
   parameter int ADDR_W  = 13,
   parameter logic [31:0] DEF_CPU = 32'hFFFA_0000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               hf_en,
   input  logic               acc_en,
   input  logic               acc_wr,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [63:0]        acc_wdata,
   output logic [63:0]        acc_rdata,
   output logic               acc_err,
   input  logic [N_LINES-1:0] irq_lines,
   input  logic               msg_ready,
   output logic               msg_valid,
   output logic [31:0]        msg_addr,
   output logic [31:0]        msg_data,
   output logic [N_LINES-1:0] pend
);
   if (DEPTH < CTRL_BASE + 2 * N_LINES) begin : g_bad_depth
      $error("table too small for the line count");
   end
   if ((N_LINES & (N_LINES - 1)) != 0 || N_LINES > 64) begin : g_bad_lines
      $error("line count must be a power of two up to 64");
   end
   if (SEL_W < $clog2(DEPTH) || ADDR_W < 12) begin : g_bad_widths
      $error("select or address width too narrow");
   end

   logic [63:0]        ctrl_w [N_LINES];
   logic [63:0]        dest_w [N_LINES];
   logic               eoi_vld;
   logic [VEC_W-1:0]   eoi_vec;
   logic [N_LINES-1:0] req_w, take_w;

   irq_redir_regs #(.DEPTH(DEPTH), .N_LINES(N_LINES), .SEL_W(SEL_W),
                    .ADDR_W(ADDR_W), .DEF_CPU(DEF_CPU)) u_regs (
      .clk, .rst, .hf_en, .acc_en, .acc_wr, .acc_addr, .acc_wdata,
      .acc_rdata, .acc_err, .ctrl_o(ctrl_w), .dest_o(dest_w),
      .eoi_vld, .eoi_vec);

   irq_redir_pend #(.N_LINES(N_LINES)) u_pend (
      .clk, .rst, .lines(irq_lines), .ctrl_i(ctrl_w), .dest_i(dest_w),
      .eoi_vld, .eoi_vec, .take(take_w), .pend, .req(req_w));

   irq_redir_msg #(.N_LINES(N_LINES)) u_msg (
      .clk, .rst, .req(req_w), .ctrl_i(ctrl_w), .dest_i(dest_w),
      .ready(msg_ready), .take(take_w), .valid(msg_valid),
      .addr(msg_addr), .data(msg_data));
endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk #(
   parameter int N_LINES = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               hf_en,
   input logic               acc_en,
   input logic [63:0]        acc_rdata,
   input logic               acc_err,
   input logic               msg_ready,
   input logic               msg_valid,
   input logic [31:0]        msg_addr,
   input logic [31:0]        msg_data,
   input logic [N_LINES-1:0] pend
);
   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
   // R8
   addr_form_chk: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> msg_addr[31:28] == 4'hF && msg_addr[11:0] == 12'h000);
   // R7
   data_range_chk: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> msg_data[31:6] == 26'd0);
   // R4
   err_gate_chk: assert property (@(posedge clk) disable iff (rst)
      acc_err |-> acc_en && hf_en && acc_rdata == 64'd0);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> pend == '0 && !msg_valid);
endmodule

bind irq_redirect irq_redirect_chk #(.N_LINES(N_LINES)) u_chk (
   .clk, .rst, .hf_en, .acc_en, .acc_rdata, .acc_err, .msg_ready,
   .msg_valid, .msg_addr, .msg_data, .pend);

// File: tb/irq_redirect_bench.sv
module irq_redirect_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        hf_en = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic [12:0] acc_addr = '0;
   logic [63:0] acc_wdata = '0;
   logic [63:0] acc_rdata;
   logic        acc_err;
   logic [7:0]  irq_lines = '0;
   logic        msg_ready = 1'b1;
   logic        msg_valid;
   logic [31:0] msg_addr, msg_data;
   logic [7:0]  pend;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit cmp_on = 1'b0;

   always #2 clk = ~clk;

   irq_redirect u_irq_redirect (.*);

   // behavioural reference model
   logic [63:0] m_tbl [32];
   logic [7:0]  m_sel, m_pend, m_prev, m_req;
   logic        m_vld;
   logic [31:0] m_addr, m_data;

   always @(posedge clk) begin
      logic [7:0] p, nr, tk;
      logic [2:0] b;
      logic [31:0] d;
      if (rst) begin
         for (int k = 0; k < 32; k++) m_tbl[k] = 64'd0;
         for (int i = 0; i < 8; i++) begin
            m_tbl[16 + 2 * i] = 64'h1A000 + 64'(i + 2);
            m_tbl[17 + 2 * i] = 64'hA0FF0000;
         end
         m_sel = 0; m_pend = 0; m_prev = 0; m_req = 0; m_vld = 0;
         m_addr = 0; m_data = 0;
      end else begin
         p = m_pend; nr = 0; tk = 0;
         if (acc_en && acc_wr && {acc_addr[12:3], 3'b0} == 13'h840)
            for (int i = 0; i < 8; i++)
               if (m_tbl[16 + 2 * i][5:0] == acc_wdata[5:0]) p[i] = 1'b0;
         for (int i = 0; i < 8; i++) begin
            if (irq_lines[i] != m_prev[i]) begin
               b = m_tbl[16 + 2 * i][2:0];
               if (irq_lines[i] && !m_tbl[16 + 2 * i][16] && m_tbl[17 + 2 * i][31:0] != 0) begin
                  if (!p[b]) nr[i] = 1'b1;
                  p[b] = 1'b1;
               end else p[b] = 1'b0;
            end
         end
         if (!m_vld || msg_ready) begin
            m_vld = 1'b0;
            for (int j = 0; j < 8; j++) begin
               if (m_req[j] && tk == 0) begin
                  tk[j] = 1'b1;
                  m_vld = 1'b1;
                  d = m_tbl[17 + 2 * j][31:0];
                  m_addr = 32'hF000_0000 | (32'(d[23:16]) << 20) | (32'(d[31:24]) << 12);
                  m_data = 32'(m_tbl[16 + 2 * j][5:0]);
               end
            end
         end
         m_req = (m_req & ~tk) | nr;
         m_pend = p;
         m_prev = irq_lines;
         if (acc_en && acc_wr && {acc_addr[12:3], 3'b0} == 13'h810 && m_sel < 32)
            m_tbl[m_sel[4:0]] = acc_wdata;
         if (acc_en && acc_wr && {acc_addr[12:3], 3'b0} == 13'h800)
            m_sel = acc_wdata[7:0];
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act %h exp %h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         chk("R5 R6 R10 pending bitmap", 64'(pend), 64'(m_pend));
         chk("R9 msg_valid", 64'(msg_valid), 64'(m_vld));
         if (m_vld) begin
            chk("R8 msg_addr", 64'(msg_addr), 64'(m_addr));
            chk("R7 msg_data", 64'(msg_data), 64'(m_data));
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog act %0d exp 20000", cyc);
         summary();
      end
   end

   task automatic wr(input logic [12:0] a, input logic [63:0] d);
      acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_en = 0; acc_wr = 0;
   endtask

   task automatic rd(input string tag, input logic [12:0] a, input logic [63:0] exp,
                     input logic exp_err);
      acc_en = 1; acc_wr = 0; acc_addr = a;
      #1;
      chk(tag, acc_rdata, exp);
      chk({tag, " err"}, 64'(acc_err), 64'(exp_err));
      @(negedge clk);
      acc_en = 0;
   endtask

   task automatic entry(input int k, input logic [63:0] d);
      wr(13'h800, 64'(k));
      wr(13'h810, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      cmp_on = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pend", 64'(pend), 64'd0);
      chk("R1 msg_valid", 64'(msg_valid), 64'd0);
      wr(13'h800, 64'd16);
      rd("R1 ctrl line0", 13'h810, 64'h1A002, 1'b0);
      wr(13'h800, 64'd31);
      rd("R1 ctrl/dest line7", 13'h810, 64'hA0FF0000, 1'b0);
      // R2 select readback
      rd("R2 select read", 13'h800, 64'd31, 1'b0);
      // R3 version
      wr(13'h800, 64'd1);
      rd("R3 version", 13'h810, 64'h00200001, 1'b0);
      // R2 window write/read on entry 5
      entry(5, 64'hDEAD_BEEF_0123_4567);
      rd("R2 window readback", 13'h810, 64'hDEAD_BEEF_0123_4567, 1'b0);
      // R4 out-of-range select and unmapped offsets
      wr(13'h800, 64'd40);
      rd("R4 sel oob hf0", 13'h810, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      hf_en = 1;
      rd("R4 sel oob hf1", 13'h810, 64'd0, 1'b1);
      rd("R4 eoi read hf1", 13'h840, 64'd0, 1'b1);
      wr(13'h100, 64'd7);
      rd("R4 unmapped hf1", 13'h100, 64'd0, 1'b1);
      hf_en = 0;
      rd("R4 unmapped hf0", 13'h100, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      wr(13'h800, 64'd5);
      rd("R4 no side effect", 13'h810, 64'hDEAD_BEEF_0123_4567, 1'b0);

      // R6 masked line 7 raises nothing
      irq_lines[7] = 1; idle(3);
      chk("R6 masked line", 64'(pend), 64'd0);
      irq_lines[7] = 0; idle(1);

      // R5 R7 R8 line 0 unmasked, vector 2
      entry(16, 64'hA002);
      irq_lines[0] = 1; idle(1);
      chk("R5 pend bit2", 64'(pend), 64'h04);
      idle(1);
      chk("R7 msg data", 64'(msg_data), 64'd2);
      chk("R8 msg addr default", 64'(msg_addr), 64'hFFFA0000);
      idle(2);
      // R6 deassert clears
      irq_lines[0] = 0; idle(1);
      chk("R6 deassert clears", 64'(pend), 64'd0);

      // R9 backlog with ready low, lowest first
      entry(18, 64'hA021);
      entry(20, 64'hA012);
      entry(22, 64'hA00B);
      msg_ready = 0;
      irq_lines[3:1] = 3'b111; idle(2);
      chk("R9 first is line1", 64'(msg_data), 64'h21);
      idle(3);
      chk("R9 stall holds", 64'(msg_data), 64'h21);
      msg_ready = 1; idle(1);
      chk("R9 second is line2", 64'(msg_data), 64'h12);
      idle(1);
      chk("R9 third is line3", 64'(msg_data), 64'h0B);
      idle(2);
      chk("R9 drained", 64'(msg_valid), 64'd0);

      // R7 aliasing vector: line 4 vector 0x09 shares bit1 -> no message
      entry(24, 64'hA009);
      irq_lines[4] = 1; idle(3);
      chk("R7 no repeat message", 64'(msg_valid), 64'd0);

      // R10 EOI by vector 0x12 clears pend bit of line 2
      chk("R10 before eoi", 64'(pend), 64'h0E);
      wr(13'h840, 64'h12);
      chk("R10 after eoi", 64'(pend), 64'h0A);

      // R5 zero destination blocks
      entry(27, 64'd0);
      entry(26, 64'hA005);
      irq_lines[5] = 1; idle(2);
      chk("R5 zero dest", 64'(pend[5]), 64'd0);

      // R8 custom destination
      entry(29, 64'h12345678);
      entry(28, 64'hA006);
      irq_lines[6] = 1; idle(2);
      chk("R8 custom addr", 64'(msg_addr), 64'hF3412000);
      chk("R7 custom data", 64'(msg_data), 64'd6);

      // random line activity with ready toggling, model compared each clock
      for (int n = 0; n < 400; n++) begin
         irq_lines = 8'($urandom);
         msg_ready = 1'($urandom);
         if (n % 17 == 0) wr(13'h840, 64'($urandom % 12));
         else idle(1);
      end
      msg_ready = 1;
      idle(10);
      summary();
   end
endmodule